// File: doc/BRIEF.md
# Nibble-Burst DRAM Device Model

This block is a clock-synchronous model of a small dynamic memory device. It is driven the way a controller drives a real part: an active-low row strobe, an active-low column strobe, an active-low write enable and one address bus that carries the row and then the column. All of these are sampled on the rising clock edge. The block is the target for a controller's testbench, and the storage is a plain register array. It has no refresh, no decay and no analog timing.

A falling row strobe latches the row. The first falling column strobe after that latches the column. Later column strobe pulses in the same row period form a nibble burst. They ignore the address pins and visit the next locations of an aligned group of four columns, wrapping inside that group. Reads drive the output bus a fixed number of clocks after the column strobe falls. The bus is released whenever the column strobe is high. Writes take the data input on the same edge that sees the column strobe fall.

Top module: `nibble_dram`

## Requirements
- R1: After reset, `dqOe` is 0 and `dqOut` is 0, and they stay so until a read is made.
- R2: The row is taken from `addr[ROW_W-1:0]` on the first clock edge that samples `rasN` low after it was high. The row stays fixed while `rasN` is low, whatever the address pins do.
- R3: The first column-strobe fall in a row period (an edge that samples `casN` low after high, with the row already open) takes the column from `addr[COL_W-1:0]`. If `weN` is 0 on that edge, `dqIn` is stored at word index {row, column}.
- R4: Whenever `casN` is high, `dqOe` is 0 and `dqOut` is 0, with no clock edge needed.
- R5: On a read, `dqOe` becomes 1 after the RD_LAT-th rising edge that samples `casN` low, counting the edge of the fall. `dqOut` then shows the stored word.
- R6: The second, third and fourth strobe falls ignore `addr`. Each one adds 1 modulo 4 to column bits [1:0] and keeps the upper column bits.
- R7: A fifth strobe fall in the same row period comes back to the starting column, and the count goes on cycling.
- R8: When `rasN` is sampled high, the access ends. The next row period samples a fresh column on its first strobe fall.
- R9: A column-strobe fall while the row strobe is high, or in the edge that opens the row, stores nothing and drives nothing.
- R10: If `casN` returns high before RD_LAT edges have passed, the read drives nothing.
- R11: While `dqOe` stays 1, `dqOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable, sampled at a column-strobe fall |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DW | Write data |
| dqOut | output | DW | Read data, 0 when not driving |
| dqOe | output | 1 | Bus drive enable; low means the pad is high-impedance |

## Verification
The assertions check on every cycle that the bus is released while the column strobe is high. They also check that a drive never starts unless the strobe was low on the previous edge, that a drive lasts as long as both strobes stay low, that the held word does not change during a drive, and that nothing is driven while the row is closed. Only the bench scenarios can show which location a strobe reaches: the column sampled on the first fall, the modulo-four stepping that ignores the pins, the wrap on the fifth pulse, the fresh column after the row closes, that writes made with the row closed do not land, and the exact latency edge.

// File: rtl/nibdram_pkg.sv
package nibdram_pkg;
  typedef struct packed {
    logic rowLoad;
    logic colLoad;
    logic colStep;
    logic memWrite;
    logic rdLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/nibdram_ctrl.sv
module nibdram_ctrl
  import nibdram_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  output ctrlStrobes_t ctl,
  output logic         dqOe
);
  localparam int CNT_W = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);

  logic             prevRas, prevCas;
  logic             rowOpen, firstDone, rdPending;
  logic [CNT_W-1:0] waitCnt;
  logic             rasFall, casFall;

  assign rasFall = prevRas && !rasN;
  assign casFall = prevCas && !casN && rowOpen && !rasN;

  always_comb begin
    ctl          = '0;
    ctl.rowLoad  = rasFall;
    ctl.colLoad  = casFall && !firstDone;
    ctl.colStep  = casFall && firstDone;
    ctl.memWrite = casFall && !weN;
    ctl.rdLoad   = casFall && weN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRas   <= 1'b1;
      prevCas   <= 1'b1;
      rowOpen   <= 1'b0;
      firstDone <= 1'b0;
      rdPending <= 1'b0;
      waitCnt   <= '0;
    end else begin
      prevRas <= rasN;
      prevCas <= casN;
      if (rasN) begin
        rowOpen   <= 1'b0;
        firstDone <= 1'b0;
        rdPending <= 1'b0;
        waitCnt   <= '0;
      end else begin
        rowOpen <= 1'b1;
        if (casFall) firstDone <= 1'b1;
        if (casN) begin
          rdPending <= 1'b0;
        end else if (ctl.rdLoad) begin
          rdPending <= 1'b1;
          waitCnt   <= CNT_W'(RD_LAT - 1);
        end else if (waitCnt != '0) begin
          waitCnt <= waitCnt - 1'b1;
        end
      end
    end
  end

  assign dqOe = rdPending && (waitCnt == '0) && !casN;
endmodule

// File: rtl/nibdram_datapath.sv
module nibdram_datapath
  import nibdram_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DW-1:0]     dqIn,
  output logic [DW-1:0]     rdData
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ, stepCol, accCol;
  logic [IDX_W-1:0] accIdx;
  logic [DW-1:0]    mem [DEPTH];

  assign stepCol = {colQ[COL_W-1:2], 2'(colQ[1:0] + 2'd1)};
  assign accCol  = ctl.colLoad ? addrIn[COL_W-1:0] : stepCol;
  assign accIdx  = {rowQ, accCol};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      rdData <= '0;
    end else begin
      if (ctl.rowLoad) rowQ <= addrIn[ROW_W-1:0];
      if (ctl.colLoad || ctl.colStep) colQ <= accCol;
      if (ctl.rdLoad) rdData <= mem[accIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.memWrite) mem[accIdx] <= dqIn;
  end
endmodule

// File: rtl/nibble_dram.sv
module nibble_dram
  import nibdram_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int DW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dqIn,
  output logic [DW-1:0]     dqOut,
  output logic              dqOe
);
  ctrlStrobes_t ctl;
  logic [DW-1:0] rdData;

  nibdram_ctrl #(.RD_LAT(RD_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .ctl(ctl), .dqOe(dqOe)
  );

  nibdram_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addr), .dqIn(dqIn), .rdData(rdData)
  );

  assign dqOut = dqOe ? rdData : '0;
endmodule

// File: rtl/nibdram_checker.sv
module nibdram_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rasN,
  input logic          casN,
  input logic          dqOe,
  input logic [DW-1:0] dqOut
);
  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    casN |-> (!dqOe && dqOut == '0));

  p_start_after_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> $past(!casN));

  p_hold_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && !rasN) |=> (dqOe || casN));

  p_stable_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && $past(dqOe)) |-> $stable(dqOut));

  p_closed_row_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && $past(rasN)) |-> !dqOe);
endmodule

bind nibble_dram nibdram_checker #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .dqOe(dqOe), .dqOut(dqOut)
);

// File: tb/nibble_dram_test.sv
module nibble_dram_test;
  localparam int ROW_W = 3, COL_W = 4, ADDR_W = 4, DW = 8, RD_LAT = 2;
  localparam int NWORD = 1 << (ROW_W + COL_W);

  logic clk = 1'b0, rstN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] dqIn = '0, dqOut;
  logic dqOe;

  always #4 clk = ~clk;

  nibble_dram #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DW(DW), .RD_LAT(RD_LAT)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [DW-1:0] refMem [NWORD];
  bit bRowOpen = 0, bFirst = 0;
  logic [ROW_W-1:0] bRow = '0;
  logic [COL_W-1:0] bCol = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] nextCol(input logic [COL_W-1:0] c);
    return {c[COL_W-1:2], 2'(c[1:0] + 2'd1)};
  endfunction

  task automatic openRow(input logic [ROW_W-1:0] r);
    @(negedge clk);
    rasN = 1'b0; addr = ADDR_W'(r);
    bRowOpen = 1; bFirst = 0; bRow = r;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic closeRow();
    @(negedge clk);
    rasN = 1'b1; bRowOpen = 0; bFirst = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic casPulse(input bit isWrite, input logic [COL_W-1:0] pinCol,
                          input logic [DW-1:0] data, input int lowCycles, input string tag);
    logic [DW-1:0] expData = '0;
    bit isRead;
    if (bRowOpen) begin
      bCol = bFirst ? nextCol(bCol) : pinCol;
      bFirst = 1;
      if (isWrite) refMem[{bRow, bCol}] = data;
      else expData = refMem[{bRow, bCol}];
    end
    isRead = bRowOpen && !isWrite;
    addr = ADDR_W'(pinCol); weN = !isWrite; dqIn = data; casN = 1'b0;
    for (int c = 1; c <= lowCycles; c++) begin
      @(posedge clk); @(negedge clk);
      chk(dqOe == (isRead && c >= RD_LAT), {tag, " R5 R10 enable"}, dqOe, isRead && c >= RD_LAT);
      if (isRead && c >= RD_LAT)
        chk(dqOut == expData, {tag, (c > RD_LAT) ? " R11" : "", " data"}, dqOut, expData);
    end
    casN = 1'b1;
    addr = ADDR_W'($urandom); weN = 1'b1;
    #1;
    chk(!dqOe && dqOut == '0, "R4 release", dqOe, 0);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!dqOe && dqOut == '0, "R1 reset", dqOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!dqOe && dqOut == '0, "R1 after reset", dqOut, 0);

    // fill every word with nibble write bursts (R3, R6)
    for (int r = 0; r < (1 << ROW_W); r++) begin
      for (int g = 0; g < (1 << (COL_W - 2)); g++) begin
        openRow(ROW_W'(r));
        for (int p = 0; p < 4; p++)
          casPulse(1, (p == 0) ? COL_W'(g * 4) : COL_W'($urandom), DW'($urandom), 1, "R3 fill");
        closeRow();
      end
    end

    // R2 R3 R6 R7: start at low bits 2, six reads, pins scrambled
    openRow(3'd5);
    for (int p = 0; p < 6; p++)
      casPulse(0, (p == 0) ? 4'hA : COL_W'($urandom), '0, RD_LAT + 1,
               (p == 0) ? "R2 R3" : (p < 4) ? "R6" : "R7");
    closeRow();

    // R9: strobe with row closed must not write
    casPulse(1, 4'h3, ~refMem[{3'd2, 4'h3}], 2, "R9 closed");
    openRow(3'd2);
    casPulse(0, 4'h3, '0, RD_LAT, "R9 readback");
    closeRow();

    // R10: pulse too short for the latency
    openRow(3'd1);
    if (RD_LAT > 1) casPulse(0, 4'h6, '0, RD_LAT - 1, "R10 short");
    closeRow();

    // R8: close mid burst, next period samples a fresh column
    openRow(3'd7);
    casPulse(0, 4'h1, '0, RD_LAT, "R3");
    casPulse(0, 4'hF, '0, RD_LAT, "R6");
    closeRow();
    openRow(3'd7);
    casPulse(0, 4'hC, '0, RD_LAT, "R8 fresh");
    casPulse(0, 4'h0, '0, RD_LAT, "R8 step");
    closeRow();

    // constrained random sessions
    for (int s = 0; s < 150; s++) begin
      openRow(ROW_W'($urandom));
      for (int p = 0; p < 1 + int'($urandom_range(5)); p++)
        casPulse($urandom_range(1), COL_W'($urandom), DW'($urandom),
                 RD_LAT + int'($urandom_range(2)), (p == 0) ? "R2 R3" : (p < 4) ? "R6" : "R7");
      closeRow();
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule